// File: doc/BRIEF.md
# Variable-Step Bit-Window Right Shifter

The block keeps a register of `W` bit elements and, each time it is triggered, moves a low window of that register towards bit 0. Both the window length (`win_len`) and the step (`step`) are runtime inputs, up to a maximum fixed at elaboration. The `step` bits at the bottom of the window fall out and leave on a shift-out port. The `step` vacated positions at the top of the window take the low `step` bits of the `fill` input. Register bits above the window keep their values.

Two trigger modes exist. In edge mode (`level_mode` = 0), a shift happens only once for each rising edge of `shift_en`. In level mode (`level_mode` = 1), a shift happens on every clock cycle while `shift_en` is high. A direct load port overwrites the whole register and takes priority over a shift. An illegal window and step pair produces a one-cycle error pulse and does not shift.

The shift-out port is a valid-only stream. `drop_valid` is high for exactly one cycle per shift, and `drop_bits` holds the discarded bits. The block has no ready input and cannot be back-pressured. A consumer must capture the bits in the cycle they are valid, because the next shift can replace them one cycle later.

Top module: `bit_window_rshift`

## Requirements
- R1: On a shift with window length n1 and step n2, the register bit at position i+n2 moves to position i, for every i below n1-n2.
- R2: On a shift, `fill` bit j (j from 0 to n2-1) is written to register position n1-n2+j. `fill` bits at or above n2 are not used.
- R3: A shift leaves register bits at positions n1 and above unchanged.
- R4: One cycle after each shift, `drop_valid` is high for one cycle. `drop_bits` holds the old register bits n2-1..0 in its low positions and zeros above them.
- R5: When `level_mode` is 0, exactly one shift happens per rising edge of `shift_en`. Holding `shift_en` high causes no further shifts.
- R6: When `level_mode` is 1, one shift happens for every clock cycle in which `shift_en` is high.
- R7: A trigger with step 0, step greater than the window length, or window length greater than `W` does not shift. In this case the register is unchanged, `drop_valid` stays low, and `param_err` is high for one cycle.
- R8: When `load` is high, the register takes `load_data` on the next edge. A shift or error requested in the same cycle is suppressed: no `drop_valid` and no `param_err`.
- R9: Synchronous active-high `rst` clears the register, `drop_valid`, `param_err` and the stored previous value of `shift_en`. As a result, when `shift_en` is already high as reset is released in edge mode, one shift follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift request; treated as an edge or a level depending on `level_mode` |
| level_mode | input | 1 | 0: one shift per rising edge of `shift_en`; 1: one shift per cycle while `shift_en` is high |
| win_len | input | $clog2(W+1) | Window length n1 |
| step | input | $clog2(W+1) | Shift distance n2 |
| fill | input | W | Refill bits; only bits step-1..0 are used |
| load | input | 1 | Direct register write; has priority over a shift |
| load_data | input | W | Value written by `load` |
| bits_q | output | W | Register contents |
| drop_bits | output | W | Bits discarded by the latest shift |
| drop_valid | output | 1 | One-cycle strobe that qualifies `drop_bits` |
| param_err | output | 1 | One-cycle pulse after a trigger with an illegal window and step pair |

## Verification
Every result is registered once. The register, `drop_bits`, `drop_valid` and `param_err` all change on the clock edge that samples the trigger, load or reset, so each result is due exactly one edge after its stimulus. The bench drives inputs on the falling edge and samples on the next falling edge, which is half a period after the edge that produces the result. Multi-cycle scenarios, such as a held enable in either mode, are sampled after every edge. This lets the bench see each strobe, and each strobe's absence, in its own cycle. The sweep covers every legal window and step pair of a 16-bit configuration against an arithmetic bit-by-bit model.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  // All-ones mask covering the low n positions; n >= width gives all ones.
  function automatic logic [255:0] low_mask(input int unsigned n, input int unsigned width);
    logic [255:0] m;
    m = '0;
    for (int unsigned i = 0; i < 256; i++)
      if (i < n && i < width) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/bwr_trigger.sv
module bwr_trigger (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic level_mode,
  output logic fire
);
  import bwr_pkg::*;

  logic en_prev;

  always_ff @(posedge clk) begin
    if (rst) en_prev <= 1'b0;
    else     en_prev <= shift_en;
  end

  always_comb begin
    if (trig_mode_e'(level_mode) == TRIG_LEVEL) fire = shift_en;
    else                                         fire = shift_en & ~en_prev;
  end
endmodule

// File: rtl/bwr_param_check.sv
module bwr_param_check #(
  parameter int W  = 64,
  localparam int NW = $clog2(W + 1)
) (
  input  logic [NW-1:0] win_len,
  input  logic [NW-1:0] step,
  output logic          legal
);
  localparam logic [NW:0] MAXLEN = (NW + 1)'(W);

  always_comb begin
    legal = (step != '0) && (step <= win_len) && ({1'b0, win_len} <= MAXLEN);
  end
endmodule

// File: rtl/bwr_datapath.sv
module bwr_datapath #(
  parameter int W  = 64,
  localparam int NW = $clog2(W + 1)
) (
  input  logic [W-1:0]  cur,
  input  logic [NW-1:0] win_len,
  input  logic [NW-1:0] step,
  input  logic [W-1:0]  fill,
  output logic [W-1:0]  nxt,
  output logic [W-1:0]  dropped
);
  logic [W-1:0]  win_mask;
  logic [W-1:0]  step_mask;
  logic [W-1:0]  moved;
  logic [W-1:0]  refill;
  logic [NW-1:0] top_pos;

  always_comb begin
    win_mask  = ~({W{1'b1}} << win_len);
    step_mask = ~({W{1'b1}} << step);
    top_pos   = win_len - step;
    moved     = (cur & win_mask) >> step;
    refill    = (fill & step_mask) << top_pos;
    nxt       = (cur & ~win_mask) | ((moved | refill) & win_mask);
    dropped   = cur & step_mask;
  end
endmodule

// File: rtl/bit_window_rshift.sv
module bit_window_rshift #(
  parameter int W  = 64,
  localparam int NW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          level_mode,
  input  logic [NW-1:0] win_len,
  input  logic [NW-1:0] step,
  input  logic [W-1:0]  fill,
  input  logic          load,
  input  logic [W-1:0]  load_data,
  output logic [W-1:0]  bits_q,
  output logic [W-1:0]  drop_bits,
  output logic          drop_valid,
  output logic          param_err
);
  logic         fire;
  logic         legal;
  logic [W-1:0] nxt;
  logic [W-1:0] dropped;

  bwr_trigger u_trig (
    .clk(clk), .rst(rst), .shift_en(shift_en), .level_mode(level_mode), .fire(fire)
  );

  bwr_param_check #(.W(W)) u_chk (
    .win_len(win_len), .step(step), .legal(legal)
  );

  bwr_datapath #(.W(W)) u_dp (
    .cur(bits_q), .win_len(win_len), .step(step), .fill(fill),
    .nxt(nxt), .dropped(dropped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q     <= '0;
      drop_bits  <= '0;
      drop_valid <= 1'b0;
      param_err  <= 1'b0;
    end else begin
      drop_valid <= 1'b0;
      param_err  <= 1'b0;
      if (load) begin
        bits_q <= load_data;
      end else if (fire) begin
        if (legal) begin
          bits_q     <= nxt;
          drop_bits  <= dropped;
          drop_valid <= 1'b1;
        end else begin
          param_err <= 1'b1;
        end
      end
    end
  end

  // R7: an error cycle never carries a shift-out strobe
  assert_err_no_shift_R7: assert property (@(posedge clk) disable iff (rst)
    !(drop_valid && param_err));

  // R7: register holds across a rejected trigger
  assert_err_holds_reg_R7: assert property (@(posedge clk) disable iff (rst)
    param_err |-> bits_q == $past(bits_q));

  // R8: load wins over any shift request
  assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (bits_q == $past(load_data)) && !drop_valid && !param_err);

  // R3: positions at or above the window are untouched by a shift
  assert_upper_kept_R3: assert property (@(posedge clk) disable iff (rst)
    drop_valid |-> (bits_q >> $past(win_len)) == ($past(bits_q) >> $past(win_len)));

  // R4: shift-out carries nothing above the step
  assert_drop_clean_R4: assert property (@(posedge clk) disable iff (rst)
    drop_valid |-> (drop_bits >> $past(step)) == '0);

  // R5: a held enable in edge mode does not shift again
  assert_edge_once_R5: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && shift_en && $past(shift_en) && !$past(rst)) |=> !drop_valid);
endmodule

// File: tb/tb_bit_window_rshift.sv
`timescale 1ns/1ps
module tb_bit_window_rshift;
  localparam int W  = 16;
  localparam int NW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          shift_en;
  logic          level_mode;
  logic [NW-1:0] win_len;
  logic [NW-1:0] step;
  logic [W-1:0]  fill;
  logic          load;
  logic [W-1:0]  load_data;
  logic [W-1:0]  bits_q;
  logic [W-1:0]  drop_bits;
  logic          drop_valid;
  logic          param_err;

  int vectors = 0;
  int misses  = 0;

  always #2 clk = ~clk;

  bit_window_rshift #(.W(W)) dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .level_mode(level_mode),
    .win_len(win_len), .step(step), .fill(fill), .load(load), .load_data(load_data),
    .bits_q(bits_q), .drop_bits(drop_bits), .drop_valid(drop_valid), .param_err(param_err)
  );

  function automatic logic [W-1:0] ref_shift(input logic [W-1:0] q, input logic [W-1:0] f,
                                            input int n1, input int n2);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      if (i >= n1)           r[i] = q[i];
      else if (i < n1 - n2)  r[i] = q[i + n2];
      else                   r[i] = f[i - (n1 - n2)];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_drop(input logic [W-1:0] q, input int n2);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) if (i < n2) r[i] = q[i];
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    shift_en = 0; load = 0;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    @(negedge clk); idle(); load = 1; load_data = v;
    @(negedge clk); load = 0;
  endtask

  initial begin
    #400000;
    misses++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [W-1:0] pat, f, exp;
    rst = 1; idle(); level_mode = 1; win_len = 0; step = 0; fill = 0; load_data = 0;
    repeat (3) @(negedge clk);
    check(bits_q == 0 && !drop_valid && !param_err, "R9 reset state", bits_q, 0);
    rst = 0;

    // R1 R2 R3 R4 sweep of every legal pair in level mode, single cycle
    for (int n1 = 1; n1 <= W; n1++) begin
      for (int n2 = 1; n2 <= n1; n2++) begin
        pat = W'($urandom); f = W'($urandom);
        do_load(pat);
        level_mode = 1; win_len = NW'(n1); step = NW'(n2); fill = f; shift_en = 1;
        @(negedge clk); shift_en = 0;
        exp = ref_shift(pat, f, n1, n2);
        check(bits_q == exp, "R1/R2/R3 shifted register", bits_q, exp);
        check(drop_valid && !param_err, "R4 strobe", {15'b0, drop_valid}, 1);
        check(drop_bits == ref_drop(pat, n2), "R4 dropped bits", drop_bits, ref_drop(pat, n2));
        @(negedge clk);
        check(!drop_valid, "R4 strobe one cycle", {15'b0, drop_valid}, 0);
      end
    end

    // R3 example: 16-bit window step 4
    do_load(16'hABCD);
    win_len = 16; step = 4; fill = 16'hFFF5; shift_en = 1; level_mode = 1;
    @(negedge clk); shift_en = 0;
    check(bits_q == 16'h5ABC, "R2 fill uses low step bits", bits_q, 16'h5ABC);
    check(drop_bits == 16'h000D, "R4 nibble out", drop_bits, 16'h000D);
    do_load(16'hF0F0);
    win_len = 8; step = 3; fill = 16'h0002; shift_en = 1;
    @(negedge clk); shift_en = 0;
    check(bits_q == 16'hF05E, "R3 upper byte kept", bits_q, 16'hF05E);

    // R5 edge mode: held enable -> one shift, re-raise -> another
    pat = 16'h1234; f = 16'h0009;
    do_load(pat);
    level_mode = 0; win_len = 12; step = 4; fill = f; shift_en = 1;
    @(negedge clk);
    check(drop_valid, "R5 first edge shifts", {15'b0, drop_valid}, 1);
    @(negedge clk);
    check(!drop_valid, "R5 held no shift", {15'b0, drop_valid}, 0);
    @(negedge clk);
    check(!drop_valid, "R5 held no shift", {15'b0, drop_valid}, 0);
    exp = ref_shift(pat, f, 12, 4);
    check(bits_q == exp, "R5 single shift result", bits_q, exp);
    shift_en = 0; @(negedge clk);
    shift_en = 1; @(negedge clk); shift_en = 0;
    exp = ref_shift(exp, f, 12, 4);
    check(drop_valid && bits_q == exp, "R5 second edge", bits_q, exp);

    // R6 level mode: three cycles high -> three shifts
    pat = 16'hC3A5; f = 16'h0006;
    do_load(pat);
    level_mode = 1; win_len = 10; step = 3; fill = f; shift_en = 1;
    exp = pat;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      exp = ref_shift(exp, f, 10, 3);
      check(drop_valid && bits_q == exp, "R6 shift per cycle", bits_q, exp);
    end
    shift_en = 0;

    // R7 illegal pairs
    for (int t = 0; t < 3; t++) begin
      pat = W'($urandom);
      do_load(pat);
      level_mode = 1; fill = '1;
      case (t)
        0: begin win_len = 8;  step = 0; end
        1: begin win_len = 5;  step = 6; end
        default: begin win_len = 17; step = 2; end
      endcase
      shift_en = 1; @(negedge clk); shift_en = 0;
      check(param_err && !drop_valid && bits_q == pat, "R7 rejected trigger", bits_q, pat);
      @(negedge clk);
      check(!param_err, "R7 error one cycle", {15'b0, param_err}, 0);
    end

    // R8 load beats shift and error
    do_load(16'h0F0F);
    level_mode = 1; win_len = 16; step = 4; fill = 0;
    load = 1; load_data = 16'h9999; shift_en = 1;
    @(negedge clk); idle();
    check(bits_q == 16'h9999 && !drop_valid, "R8 load priority", bits_q, 16'h9999);
    step = 0; load = 1; load_data = 16'h7777; shift_en = 1;
    @(negedge clk); idle();
    check(bits_q == 16'h7777 && !param_err, "R8 load suppresses error", bits_q, 16'h7777);

    // R9 reset clears enable history: en high across reset in edge mode
    level_mode = 0; win_len = 16; step = 4; fill = 16'h000A; shift_en = 1; rst = 1;
    @(negedge clk);
    check(bits_q == 0 && !drop_valid && !param_err, "R9 reset clears", bits_q, 0);
    rst = 0;
    @(negedge clk);
    check(drop_valid && bits_q == 16'hA000, "R9 shift after reset", bits_q, 16'hA000);
    shift_en = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule